// File: doc/BRIEF.md
# Erase and Program Status Bit Generator

This block supplies the byte a host sees on the data bus of a byte-wide, sectored flash model while an internal program or erase algorithm runs. It holds a small array (inferable as dual-port block RAM) and a controller for the algorithm. The controller keeps the set of sectors chosen for erasure, whether erasure is running or suspended, and a pulse counter with a limit. Each read returns either stored array data or a status byte. That byte carries two independent toggle bits and a timeout flag.

One toggle bit (bit 6) reports that an algorithm is actively running, and it freezes while erasure is suspended. The other toggle bit (bit 2) inverts only on reads that address a sector chosen for erasure, both while erasure is running and while it is suspended. A host needs both bits to learn the mode and the sector. Commands arrive as single-cycle start, suspend, resume and reset pulses. A read is strobed by either of two enables.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the block is idle. rd_valid is low with no read pending, and every read returns `rd_valid` high exactly two clock edges after the edge that samples its strobe. The array powers up holding 0xFF.
- R2: A read cycle is any cycle with `rd_oe` or `rd_ce` high. Both high together count as one read and advance each toggle bit at most once.
- R3: While erasure or programming is active, status bit 6 reads 0 on the first read after the start command and inverts on every further read.
- R4: While erasure is active, status bit 2 inverts on each read whose sector (the top SW address bits) is selected for erasure and holds its value on reads of other sectors.
- R5: During erase suspend, a read of a selected sector returns status in which bit 6 holds its value and bit 2 inverts. A suspend command is honoured only while erasure is active.
- R6: During erase suspend, a read of an unselected sector returns stored array data.
- R7: A read sampled on the same edge as a start command returns array-mode data. Status begins with the next read, and both toggle bits restart from 0 at every start.
- R8: Programming a location that holds 0xFF shows status with bit 2 held. It finishes PROG_CYCLES cycles after the start, and that location then reads the new data.
- R9: Programming a location that does not hold 0xFF never finishes. Bit 6 keeps toggling, and bit 5 reads 0 until PULSE_LIMIT active cycles have passed and 1 from then on.
- R10: After a timeout, start and suspend commands are ignored and reads keep returning status with bit 5 set. Only the reset command returns the block to array reads.
- R11: On completion of an erase that was suspended and then resumed, every byte of the selected sectors reads 0xFF. Unselected sectors keep their contents.
- R12: Status bits 7, 4, 3, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_erase | input | 1 | Start erasure of the sectors in cmd_sel (idle only, non-empty mask) |
| cmd_sel | input | 2**SW | Sector selection mask for erasure |
| cmd_prog | input | 1 | Start programming cmd_data at cmd_addr (idle only) |
| cmd_addr | input | AW | Program address |
| cmd_data | input | 8 | Program data |
| cmd_suspend | input | 1 | Suspend running erasure |
| cmd_resume | input | 1 | Resume suspended erasure |
| cmd_reset | input | 1 | Leave the timeout state |
| rd_oe | input | 1 | Read strobe, output-enable style |
| rd_ce | input | 1 | Read strobe, chip-enable style |
| rd_addr | input | AW | Read address |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Array data or status byte |

## Verification
Every read result is due on the second clock edge after the edge that samples its strobe. The toggle flops advance on that sampling edge. Commands take effect on the edge that samples them, so a read on that same edge still sees the old mode. Program completion falls PROG_CYCLES cycles after the start, and the timeout falls PULSE_LIMIT active cycles after it. The bench pushes one expected byte into a queue for each strobe, and the monitor, at each falling edge, pops one entry per valid result. The bench waits well past the completion and timeout points before it relies on a mode change, so the checks never depend on the exact completion edge.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_ERASE = 3'd1,
    M_SUSP  = 3'd2,
    M_PROG  = 3'd3,
    M_FAIL  = 3'd4
  } alg_mode_e;

  localparam int unsigned DW        = 8;
  localparam int unsigned BIT_RUN   = 6;
  localparam int unsigned BIT_TOUT  = 5;
  localparam int unsigned BIT_SECT  = 2;
  localparam logic [DW-1:0] BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/fsg_array.sv
module fsg_array #(
  parameter int AW = 8
) (
  input  logic                                 clk,
  input  logic [AW-1:0]                        a_addr,
  input  logic                                 a_we,
  input  logic [flash_status_pkg::DW-1:0]      a_wdata,
  output logic [flash_status_pkg::DW-1:0]      a_q,
  input  logic [AW-1:0]                        b_addr,
  output logic [flash_status_pkg::DW-1:0]      b_q
);
  import flash_status_pkg::*;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = BLANK_BYTE;
  end

  // port A: algorithm side, read-first
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_q <= mem[a_addr];
  end

  // port B: host read side
  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/fsg_algo_ctrl.sv
module fsg_algo_ctrl
  import flash_status_pkg::*;
#(
  parameter int AW          = 8,
  parameter int SW          = 2,
  parameter int PULSE_LIMIT = 512,
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_erase,
  input  logic [(1<<SW)-1:0] cmd_sel,
  input  logic              cmd_prog,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [DW-1:0]     cmd_data,
  input  logic              cmd_suspend,
  input  logic              cmd_resume,
  input  logic              cmd_reset,
  input  logic [DW-1:0]     arr_q,
  output alg_mode_e         mode,
  output logic [(1<<SW)-1:0] sel_mask,
  output logic              erase_job,
  output logic              clear_tgl,
  output logic [AW-1:0]     a_addr,
  output logic              a_we,
  output logic [DW-1:0]     a_wdata
);
  localparam int NSECT = 1 << SW;
  localparam int CW    = $clog2(PULSE_LIMIT + 1);
  localparam logic [CW-1:0] LIM_LAST = CW'(PULSE_LIMIT - 1);
  localparam logic [CW-1:0] PRG_LAST = CW'(PROG_CYCLES - 1);

  alg_mode_e        mode_q;
  logic [CW-1:0]    pcnt_q;
  logic [AW-1:0]    ptr_q;
  logic [AW-1:0]    paddr_q;
  logic [DW-1:0]    pdata_q;
  logic [NSECT-1:0] sel_q;
  logic             job_q;

  logic start_e, start_p, active, erase_wr, erase_last, prog_ok, limit_hit;

  always_comb begin
    start_e    = (mode_q == M_IDLE) && cmd_erase && (|cmd_sel);
    start_p    = (mode_q == M_IDLE) && cmd_prog && !start_e;
    active     = (mode_q == M_ERASE) || (mode_q == M_PROG);
    erase_wr   = (mode_q == M_ERASE) && sel_q[ptr_q[AW-1 -: SW]];
    erase_last = (mode_q == M_ERASE) && (&ptr_q);
    prog_ok    = (mode_q == M_PROG) && (pcnt_q == PRG_LAST) && (arr_q == BLANK_BYTE);
    limit_hit  = active && (pcnt_q == LIM_LAST) && !erase_last && !prog_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_IDLE;
      pcnt_q  <= '0;
      ptr_q   <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
      sel_q   <= '0;
      job_q   <= 1'b0;
    end else begin
      unique case (mode_q)
        M_IDLE: begin
          if (start_e) begin
            mode_q <= M_ERASE;
            sel_q  <= cmd_sel;
            ptr_q  <= '0;
            pcnt_q <= '0;
            job_q  <= 1'b1;
          end else if (start_p) begin
            mode_q  <= M_PROG;
            paddr_q <= cmd_addr;
            pdata_q <= cmd_data;
            pcnt_q  <= '0;
            job_q   <= 1'b0;
          end
        end
        M_ERASE: begin
          pcnt_q <= pcnt_q + 1'b1;
          ptr_q  <= ptr_q + 1'b1;
          if (limit_hit)        mode_q <= M_FAIL;
          else if (erase_last)  mode_q <= M_IDLE;
          else if (cmd_suspend) mode_q <= M_SUSP;
        end
        M_SUSP: begin
          if (cmd_resume) mode_q <= M_ERASE;
        end
        M_PROG: begin
          pcnt_q <= pcnt_q + 1'b1;
          if (prog_ok)        mode_q <= M_IDLE;
          else if (limit_hit) mode_q <= M_FAIL;
        end
        M_FAIL: begin
          if (cmd_reset) mode_q <= M_IDLE;
        end
        default: mode_q <= M_IDLE;
      endcase
    end
  end

  always_comb begin
    mode      = mode_q;
    sel_mask  = sel_q;
    erase_job = job_q;
    clear_tgl = start_e || start_p;
    a_addr    = (mode_q == M_ERASE) ? ptr_q : paddr_q;
    a_we      = erase_wr || prog_ok;
    a_wdata   = erase_wr ? BLANK_BYTE : pdata_q;
  end

  // R10
  fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_FAIL && !cmd_reset) |=> (mode_q == M_FAIL));

  // R5
  susp_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q == M_SUSP) |-> $past(mode_q == M_ERASE && cmd_suspend));

  // R9
  timeout_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q == M_FAIL) |-> ($past(pcnt_q) == LIM_LAST));

  // R11
  erase_target_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_ERASE && a_we) |-> sel_q[a_addr[AW-1 -: SW]]);
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle
  import flash_status_pkg::*;
#(
  parameter int SW = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  alg_mode_e          mode,
  input  logic [(1<<SW)-1:0] sel_mask,
  input  logic               erase_job,
  input  logic               clear_tgl,
  input  logic               rd_go,
  input  logic [SW-1:0]      rd_sect,
  output logic [DW-1:0]      st_byte_q,
  output logic               use_stat_q,
  output logic               vld_q
);
  logic t6_q, t2_q;
  logic in_sel, show_stat, flip6, flip2;
  logic [DW-1:0] st_byte;

  always_comb begin
    in_sel    = sel_mask[rd_sect];
    show_stat = 1'b0;
    flip6     = 1'b0;
    flip2     = 1'b0;
    unique case (mode)
      M_ERASE: begin show_stat = 1'b1;   flip6 = 1'b1; flip2 = in_sel;             end
      M_SUSP:  begin show_stat = in_sel; flip6 = 1'b0; flip2 = in_sel;             end
      M_PROG:  begin show_stat = 1'b1;   flip6 = 1'b1; flip2 = 1'b0;               end
      M_FAIL:  begin show_stat = 1'b1;   flip6 = 1'b1; flip2 = erase_job && in_sel; end
      default: begin show_stat = 1'b0;   flip6 = 1'b0; flip2 = 1'b0;               end
    endcase
    st_byte           = '0;
    st_byte[BIT_RUN]  = t6_q;
    st_byte[BIT_TOUT] = (mode == M_FAIL);
    st_byte[BIT_SECT] = t2_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t6_q       <= 1'b0;
      t2_q       <= 1'b0;
      st_byte_q  <= '0;
      use_stat_q <= 1'b0;
      vld_q      <= 1'b0;
    end else begin
      if (clear_tgl) begin
        t6_q <= 1'b0;
        t2_q <= 1'b0;
      end else if (rd_go) begin
        t6_q <= t6_q ^ flip6;
        t2_q <= t2_q ^ flip2;
      end
      st_byte_q  <= st_byte;
      use_stat_q <= rd_go && show_stat;
      vld_q      <= rd_go;
    end
  end

  // R5
  susp_run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_SUSP && rd_go && !clear_tgl) |=> $stable(t6_q));

  // R4
  erase_sect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_ERASE && rd_go && !sel_mask[rd_sect]) |=> $stable(t2_q));

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear_tgl |=> (!t6_q && !t2_q));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int AW          = 8,
  parameter int SW          = 2,
  parameter int PULSE_LIMIT = 512,
  parameter int PROG_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_erase,
  input  logic [(1<<SW)-1:0] cmd_sel,
  input  logic               cmd_prog,
  input  logic [AW-1:0]      cmd_addr,
  input  logic [7:0]         cmd_data,
  input  logic               cmd_suspend,
  input  logic               cmd_resume,
  input  logic               cmd_reset,
  input  logic               rd_oe,
  input  logic               rd_ce,
  input  logic [AW-1:0]      rd_addr,
  output logic               rd_valid,
  output logic [7:0]         rd_data
);
  localparam int NSECT = 1 << SW;

  alg_mode_e        mode;
  logic [NSECT-1:0] sel_mask;
  logic             erase_job, clear_tgl;
  logic [AW-1:0]    a_addr;
  logic             a_we;
  logic [DW-1:0]    a_wdata, a_q, b_q;
  logic [DW-1:0]    st_byte_q;
  logic             use_stat_q, vld_q;
  logic             rd_go;

  assign rd_go = rd_oe | rd_ce;

  fsg_algo_ctrl #(
    .AW(AW), .SW(SW), .PULSE_LIMIT(PULSE_LIMIT), .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_erase(cmd_erase), .cmd_sel(cmd_sel), .cmd_prog(cmd_prog),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
    .arr_q(a_q), .mode(mode), .sel_mask(sel_mask), .erase_job(erase_job),
    .clear_tgl(clear_tgl), .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata)
  );

  fsg_array #(.AW(AW)) u_array (
    .clk(clk), .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_q(a_q),
    .b_addr(rd_addr), .b_q(b_q)
  );

  fsg_toggle #(.SW(SW)) u_toggle (
    .clk(clk), .rst(rst), .mode(mode), .sel_mask(sel_mask),
    .erase_job(erase_job), .clear_tgl(clear_tgl), .rd_go(rd_go),
    .rd_sect(rd_addr[AW-1 -: SW]),
    .st_byte_q(st_byte_q), .use_stat_q(use_stat_q), .vld_q(vld_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= vld_q;
      rd_data  <= use_stat_q ? st_byte_q : b_q;
    end
  end

  // R1
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_go |-> ##2 rd_valid);
endmodule

// File: tb/flash_status_gen_tb.sv
`timescale 1ns/1ps
module flash_status_gen_tb;
  localparam int AW = 8;
  localparam int SW = 2;
  localparam int PULSE_LIMIT = 512;
  localparam int PROG_CYCLES = 16;
  localparam int B_IDLE = 0, B_ERASE = 1, B_SUSP = 2, B_PROG = 3, B_FAIL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_erase = 0, cmd_prog = 0, cmd_suspend = 0, cmd_resume = 0, cmd_reset = 0;
  logic [3:0] cmd_sel = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic rd_oe = 0, rd_ce = 0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_valid;
  logic [7:0] rd_data;

  always #4 clk = ~clk;

  flash_status_gen #(.AW(AW), .SW(SW), .PULSE_LIMIT(PULSE_LIMIT), .PROG_CYCLES(PROG_CYCLES)) u_dut (
    .clk(clk), .rst(rst), .cmd_erase(cmd_erase), .cmd_sel(cmd_sel), .cmd_prog(cmd_prog),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_suspend(cmd_suspend),
    .cmd_resume(cmd_resume), .cmd_reset(cmd_reset), .rd_oe(rd_oe), .rd_ce(rd_ce),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] exq[$];
  string      tgq[$];

  // bench-side model of the requirements
  logic [7:0] am [256];
  int   bmode = B_IDLE;
  logic [3:0] bsel = '0;
  bit   bjob = 0;
  logic m6 = 0, m2 = 0;

  function automatic logic [7:0] sbyte(logic r6, logic t5, logic s2);
    return {1'b0, r6, t5, 2'b00, s2, 2'b00};  // R12: other bits zero
  endfunction

  task automatic model_read(input logic [7:0] a, output logic [7:0] e);
    logic ins;
    ins = bsel[a[7:6]];
    case (bmode)
      B_ERASE: begin e = sbyte(m6, 0, m2); m6 = ~m6; if (ins) m2 = ~m2; end
      B_SUSP:  begin if (ins) begin e = sbyte(m6, 0, m2); m2 = ~m2; end else e = am[a]; end
      B_PROG:  begin e = sbyte(m6, 0, m2); m6 = ~m6; end
      B_FAIL:  begin e = sbyte(m6, 1, m2); m6 = ~m6; if (bjob && ins) m2 = ~m2; end
      default: e = am[a];
    endcase
  endtask

  // driver: caller is at a falling edge
  task automatic rd(input logic [7:0] a, input bit oe, input bit ce, input string tag);
    logic [7:0] e;
    model_read(a, e);
    rd_addr = a; rd_oe = oe; rd_ce = ce;
    exq.push_back(e); tgq.push_back(tag);
    @(negedge clk);
    rd_oe = 0; rd_ce = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_prog(input logic [7:0] a, input logic [7:0] d);
    cmd_prog = 1; cmd_addr = a; cmd_data = d;
    bmode = B_PROG; bjob = 0; m6 = 0; m2 = 0;
    @(negedge clk); cmd_prog = 0;
  endtask

  task automatic pulse_suspend(); cmd_suspend = 1; @(negedge clk); cmd_suspend = 0; endtask
  task automatic pulse_resume();  cmd_resume  = 1; @(negedge clk); cmd_resume  = 0; endtask
  task automatic pulse_reset();   cmd_reset   = 1; @(negedge clk); cmd_reset   = 0; endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exq.size() == 0) begin
        failures++;
        $display("FAIL R1 unexpected result: actual=%02h expected=none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exq.pop_front();
        t = tgq.pop_front();
        if (rd_data !== e) begin
          failures++;
          $display("FAIL %s: actual=%02h expected=%02h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    #(8ns * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) am[i] = 8'hFF;
    idle(4);
    rst = 0;
    idle(2);
    checks++;
    if (rd_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset valid: actual=%0b expected=0", rd_valid);
    end

    // R1 / R2: array reads, each strobe style
    rd(8'h10, 1, 0, "R1 blank array via oe");
    rd(8'h20, 0, 1, "R2 array via ce");
    rd(8'h30, 1, 1, "R2 array via both");

    // R8 / R2 / R3: blank program
    start_prog(8'h50, 8'h00);
    rd(8'h50, 1, 0, "R3 program first read");
    rd(8'h50, 0, 1, "R3 program second read ce");
    rd(8'h50, 1, 1, "R2 both strobes one toggle");
    rd(8'h51, 1, 0, "R8 program bit2 held");
    idle(30); bmode = B_IDLE; am[8'h50] = 8'h00;
    rd(8'h50, 1, 0, "R8 programmed data");
    start_prog(8'h05, 8'h3C);
    idle(30); bmode = B_IDLE; am[8'h05] = 8'h3C;
    rd(8'h05, 0, 1, "R8 programmed data 2");

    // R7: read on the start edge returns array data
    begin
      logic [7:0] e;
      model_read(8'h05, e);
      cmd_erase = 1; cmd_sel = 4'b0010; rd_oe = 1; rd_addr = 8'h05;
      exq.push_back(e); tgq.push_back("R7 read on start edge");
      @(negedge clk);
      cmd_erase = 0; rd_oe = 0;
      bmode = B_ERASE; bsel = 4'b0010; bjob = 1; m6 = 0; m2 = 0;
    end
    rd(8'h45, 1, 0, "R7 first status read");
    rd(8'h45, 0, 1, "R3 erase toggle");
    rd(8'h05, 1, 0, "R4 unselected sector holds bit2");
    rd(8'h7F, 1, 0, "R4 selected sector toggles bit2");

    // R5 / R6: suspend
    pulse_suspend(); bmode = B_SUSP;
    rd(8'h45, 1, 0, "R5 suspend selected read");
    rd(8'h46, 0, 1, "R5 suspend bit6 held");
    rd(8'h50, 1, 0, "R5 suspend bit2 toggles");
    rd(8'h05, 1, 0, "R6 suspend unselected array");
    rd(8'h80, 0, 1, "R6 suspend unselected blank");
    pulse_resume(); bmode = B_ERASE;
    rd(8'h45, 1, 0, "R3 resumed erase toggles");

    // R11: completion
    idle(300); bmode = B_IDLE;
    for (int i = 8'h40; i < 8'h80; i++) am[i] = 8'hFF;
    rd(8'h50, 1, 0, "R11 selected sector erased");
    rd(8'h7F, 1, 0, "R11 selected sector end erased");
    rd(8'h05, 0, 1, "R11 unselected sector kept");

    // R9: program over non-blank data
    start_prog(8'h05, 8'h11);
    rd(8'h05, 1, 0, "R9 bit5 low before limit");
    rd(8'h05, 1, 0, "R9 still toggling");
    idle(PULSE_LIMIT + 60); bmode = B_FAIL;
    rd(8'h05, 1, 0, "R9 timeout bit5 high");
    rd(8'h45, 0, 1, "R9 timeout bit6 toggles");

    // R10: commands ignored after timeout, reset recovers
    cmd_erase = 1; cmd_sel = 4'b0001; @(negedge clk); cmd_erase = 0;
    pulse_suspend();
    start_prog(8'h90, 8'h00); bmode = B_FAIL; m6 = 1'b0;
    rd(8'h05, 1, 0, "R10 start and suspend ignored");
    rd(8'h10, 1, 0, "R10 status persists");
    pulse_reset(); bmode = B_IDLE;
    rd(8'h05, 1, 0, "R10 array after reset");
    rd(8'h90, 0, 1, "R10 ignored program left blank");
    rd(8'h10, 1, 1, "R10 ignored erase left data");

    idle(5);
    checks++;
    if (exq.size() != 0) begin
      failures++;
      $display("FAIL R1 missing results: actual=%0d expected=0", exq.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule